// File: doc/BRIEF.md
# Dual Event Timestamp Queue

This block records the time of day whenever a receive-side or a transmit-side event strobe is high on a clock edge. Each record is 64 bits wide: a 32-bit seconds field and a 32-bit nanoseconds field taken from the time bus. Receive and transmit records go into two independent first-in first-out queues.

Software reaches the queues through a small register port. A status register for each queue reports how many records it holds. Software asks for the oldest record with a command bit in a shared control register. It then polls that same bit until it reads back as one, and reads the record as a seconds word and a nanoseconds word. A dedicated command value empties both queues.

Top module: `tsq_unit`

## Requirements
- R1: A clock edge with `rx_evt` high appends `{tod_sec, tod_ns}` to the receive queue, and one with `tx_evt` high appends it to the transmit queue. The two queues are independent.
- R2: Reading 0x54 returns the receive queue count and reading 0x58 returns the transmit queue count, both in bits [4:0], with bit 31 as that queue's overflow flag and every other bit zero. Reading any unmapped address returns zero.
- R3: A write to 0x50 whose bit 2 goes from 0 to 1, compared with the previously written control value, removes the oldest receive record and loads its seconds into 0x60 and its nanoseconds into 0x64. Bit 0 does the same for the transmit queue, loading 0x68 (seconds) and 0x6C (nanoseconds). Records leave in arrival order.
- R4: After such a pop, control bit 2 (receive) or bit 0 (transmit) reads 1 from the next cycle. It stays 1 until a write to 0x50 clears that bit. All other control read bits are zero.
- R5: A control write whose command bit was already 1 in the previous control write neither pops nor changes any count or data register.
- R6: Each queue holds at most 16 records. A capture into a full queue with no pop in the same cycle is dropped, and the queue's overflow flag is set and stays set.
- R7: A pop from an empty queue leaves its data registers unchanged, leaves the count at zero, and still sets the completion bit.
- R8: A capture and a pop on the same queue in the same cycle both take effect. The count is unchanged, and a full queue accepts the new record.
- R9: A control write with bits 3 and 1 both set, when they were not both set in the previous control write, empties both queues and clears both overflow flags and both completion bits. The data registers keep their values, and pops and captures in that cycle are discarded.
- R10: While `rst_n` is low, all counts, flags and data registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tod_sec | input | 32 | Time of day, seconds |
| tod_ns | input | 32 | Time of day, nanoseconds |
| rx_evt | input | 1 | Receive event strobe |
| tx_evt | input | 1 | Transmit event strobe |
| reg_wen | input | 1 | Register write enable |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
The queues are driven with several kinds of traffic, each aimed at a different fault:
- Interleaved receive and transmit captures with distinct time values expose cross-lane mixing and ordering errors.
- Filling the transmit queue beyond sixteen records separates a correct drop-and-flag from a wrap-around overwrite.
- Pops repeated without an intervening zero write catch level-triggered command decoding instead of edge-triggered.
- A pop from an empty queue and a capture coinciding with a pop on a full queue probe the count arithmetic at both ends.

A long random mix of strobes, commands and flushes is then compared, cycle by cycle, with a behavioural queue model.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam logic [7:0] ADR_CTRL  = 8'h50;
  localparam logic [7:0] ADR_RXCNT = 8'h54;
  localparam logic [7:0] ADR_TXCNT = 8'h58;
  localparam logic [7:0] ADR_RXHI  = 8'h60;
  localparam logic [7:0] ADR_RXLO  = 8'h64;
  localparam logic [7:0] ADR_TXHI  = 8'h68;
  localparam logic [7:0] ADR_TXLO  = 8'h6C;

  // command bit positions in the control word
  localparam int CB_POP_TX = 0;
  localparam int CB_FLUSH0 = 1;
  localparam int CB_POP_RX = 2;
  localparam int CB_FLUSH1 = 3;

  // lane indices
  localparam int LANE_RX = 0;
  localparam int LANE_TX = 1;
  localparam int NLANES  = 2;

  typedef struct packed {
    logic [31:0] sec;
    logic [31:0] ns;
  } stamp_t;

  function automatic logic rise(input logic now_v, input logic old_v);
    return now_v & ~old_v;
  endfunction

  function automatic logic [31:0] status_word(input logic ovf, input logic [15:0] cnt);
    return {ovf, 15'd0, cnt};
  endfunction
endpackage

// File: rtl/tsq_cmd_decode.sv
module tsq_cmd_decode
  import tsq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic              flush,
  output logic              pop_rx,
  output logic              pop_tx,
  output logic              clr_rx,
  output logic              clr_tx
);
  logic [3:0] ctrl_q;
  logic       ctrl_wr;
  logic       flush_old;
  logic       flush_new;

  assign ctrl_wr   = wen && (addr == ADDR_W'(ADR_CTRL));
  assign flush_old = ctrl_q[CB_FLUSH0] & ctrl_q[CB_FLUSH1];
  assign flush_new = wdata[CB_FLUSH0] & wdata[CB_FLUSH1];
  assign flush     = ctrl_wr && rise(flush_new, flush_old);
  assign pop_rx    = ctrl_wr && !flush && rise(wdata[CB_POP_RX], ctrl_q[CB_POP_RX]);
  assign pop_tx    = ctrl_wr && !flush && rise(wdata[CB_POP_TX], ctrl_q[CB_POP_TX]);
  assign clr_rx    = ctrl_wr && !wdata[CB_POP_RX];
  assign clr_tx    = ctrl_wr && !wdata[CB_POP_TX];

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wdata[3:0];
  end

  // R5: a command bit that was already set never produces a pop
  p_no_retrigger_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_q[CB_POP_RX] && wdata[CB_POP_RX]) |-> !pop_rx);
  // R9: flush and pop never coincide
  p_flush_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !(pop_rx || pop_tx));
endmodule

// File: rtl/tsq_fifo.sv
module tsq_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             ovf,
  output logic             push_fire,
  output logic             pop_fire,
  output logic             drop
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             full;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c,
                                                 input logic inc, input logic dec);
    logic [CNT_W-1:0] r;
    r = c;
    if (inc && !dec) r = c + 1'b1;
    if (dec && !inc) r = c - 1'b1;
    return r;
  endfunction

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign pop_fire  = pop && !empty && !flush;
  assign push_fire = push && !flush && (!full || pop_fire);
  assign drop      = push && !flush && full && !pop_fire;
  assign head      = mem[rd_ptr];
  assign count     = cnt_q;
  assign ovf       = ovf_q;

  always_ff @(posedge clk) begin
    if (push_fire) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (push_fire) wr_ptr <= ptr_next(wr_ptr);
      if (pop_fire)  rd_ptr <= ptr_next(rd_ptr);
      cnt_q <= cnt_next(cnt_q, push_fire, pop_fire);
      if (drop) ovf_q <= 1'b1;
    end
  end

  // R6: occupancy never exceeds the depth
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  // R6: a dropped capture leaves the queue full and flagged
  p_drop_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (cnt_q == CNT_W'(DEPTH)) && ovf_q);
  // R8: simultaneous push and pop keep the count
  p_push_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && pop_fire) |=> $stable(cnt_q));
  // R9: flush empties the queue and clears overflow
  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0) && !ovf_q);
endmodule

// File: rtl/tsq_lane.sv
module tsq_lane
  import tsq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             evt,
  input  stamp_t           stamp,
  input  logic             pop,
  input  logic             clr,
  output stamp_t           data_q,
  output logic             done_q,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  logic [63:0] head_raw;
  logic        empty;
  logic        push_fire, pop_fire, drop;
  stamp_t      head;

  tsq_fifo #(.DEPTH(DEPTH), .W(64)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (evt),
    .din       (stamp),
    .pop       (pop),
    .head      (head_raw),
    .count     (count),
    .empty     (empty),
    .ovf       (ovf),
    .push_fire (push_fire),
    .pop_fire  (pop_fire),
    .drop      (drop)
  );

  assign head = stamp_t'(head_raw);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (pop_fire) data_q <= head;
      if (flush)    done_q <= 1'b0;
      else if (pop) done_q <= 1'b1;
      else if (clr) done_q <= 1'b0;
    end
  end

  // R4: completion flag follows every accepted pop command
  p_done_after_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !flush) |=> done_q);
  // R7: popping an empty queue keeps the data registers
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> $stable(data_q));
endmodule

// File: rtl/tsq_unit.sv
module tsq_unit
  import tsq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       tod_sec,
  input  logic [31:0]       tod_ns,
  input  logic              rx_evt,
  input  logic              tx_evt,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  logic       flush, pop_rx, pop_tx, clr_rx, clr_tx;
  stamp_t     stamp;
  logic       lane_evt  [NLANES];
  logic       lane_pop  [NLANES];
  logic       lane_clr  [NLANES];
  stamp_t     lane_data [NLANES];
  logic       lane_done [NLANES];
  logic [CNT_W-1:0] lane_cnt [NLANES];
  logic       lane_ovf  [NLANES];

  assign stamp = '{sec: tod_sec, ns: tod_ns};

  tsq_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .wen    (reg_wen),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .flush  (flush),
    .pop_rx (pop_rx),
    .pop_tx (pop_tx),
    .clr_rx (clr_rx),
    .clr_tx (clr_tx)
  );

  assign lane_evt[LANE_RX] = rx_evt;
  assign lane_evt[LANE_TX] = tx_evt;
  assign lane_pop[LANE_RX] = pop_rx;
  assign lane_pop[LANE_TX] = pop_tx;
  assign lane_clr[LANE_RX] = clr_rx;
  assign lane_clr[LANE_TX] = clr_tx;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    tsq_lane #(.DEPTH(DEPTH)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (flush),
      .evt    (lane_evt[g]),
      .stamp  (stamp),
      .pop    (lane_pop[g]),
      .clr    (lane_clr[g]),
      .data_q (lane_data[g]),
      .done_q (lane_done[g]),
      .count  (lane_cnt[g]),
      .ovf    (lane_ovf[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(ADR_CTRL): begin
        reg_rdata[CB_POP_TX] = lane_done[LANE_TX];
        reg_rdata[CB_POP_RX] = lane_done[LANE_RX];
      end
      ADDR_W'(ADR_RXCNT): reg_rdata = status_word(lane_ovf[LANE_RX], 16'(lane_cnt[LANE_RX]));
      ADDR_W'(ADR_TXCNT): reg_rdata = status_word(lane_ovf[LANE_TX], 16'(lane_cnt[LANE_TX]));
      ADDR_W'(ADR_RXHI):  reg_rdata = lane_data[LANE_RX].sec;
      ADDR_W'(ADR_RXLO):  reg_rdata = lane_data[LANE_RX].ns;
      ADDR_W'(ADR_TXHI):  reg_rdata = lane_data[LANE_TX].sec;
      ADDR_W'(ADR_TXLO):  reg_rdata = lane_data[LANE_TX].ns;
      default:            reg_rdata = '0;
    endcase
  end

  // R10: state is cleared one edge after reset is sampled
  p_reset_clear_r10: assert property (@(posedge clk)
    !rst_n |=> (lane_cnt[LANE_RX] == '0) && (lane_cnt[LANE_TX] == '0)
               && !lane_done[LANE_RX] && !lane_done[LANE_TX]);
  // R1: a capture into a non-full, non-flushed queue raises its count
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt && !flush && !pop_rx && lane_cnt[LANE_RX] < CNT_W'(DEPTH))
      |=> lane_cnt[LANE_RX] == $past(lane_cnt[LANE_RX]) + 1'b1);
endmodule

// File: tb/sim_tsq_unit.sv
module sim_tsq_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] tod_sec, tod_ns;
  logic        rx_evt, tx_evt, reg_wen;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  string cur_tag = "R10";

  // behavioural reference state: index 0 receive, 1 transmit
  logic [63:0] mq [2][$];
  logic [63:0] m_data [2];
  bit          m_done [2];
  bit          m_ovf  [2];
  logic [3:0]  m_ctrl;
  logic [31:0] tsec, tns;

  always #5 clk = ~clk;

  tsq_unit u0 (
    .clk(clk), .rst_n(rst_n), .tod_sec(tod_sec), .tod_ns(tod_ns),
    .rx_evt(rx_evt), .tx_evt(tx_evt), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h50: return {29'd0, m_done[0], 1'b0, m_done[1]};
      8'h54: return {m_ovf[0], 26'd0, 5'(mq[0].size())};
      8'h58: return {m_ovf[1], 26'd0, 5'(mq[1].size())};
      8'h60: return m_data[0][63:32];
      8'h64: return m_data[0][31:0];
      8'h68: return m_data[1][63:32];
      8'h6C: return m_data[1][31:0];
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input logic [7:0] a);
    logic [31:0] e;
    reg_addr = a;
    #1;
    e = exp_read(a);
    vectors++;
    if (reg_rdata !== e) begin
      miscompares++;
      $display("FAIL %s addr %02h actual %08h expected %08h", cur_tag, a, reg_rdata, e);
    end
  endtask

  task automatic model_reset();
    for (int l = 0; l < 2; l++) begin
      mq[l].delete(); m_data[l] = '0; m_done[l] = 0; m_ovf[l] = 0;
    end
    m_ctrl = '0;
  endtask

  task automatic model_step(input bit wen, input logic [7:0] a, input logic [31:0] wd,
                            input bit rxe, input bit txe, input logic [63:0] st);
    bit cmd, fl;
    bit pop [2];
    bit ev [2];
    bit clr [2];
    cmd = wen && (a == 8'h50);
    fl  = cmd && wd[3] && wd[1] && !(m_ctrl[3] && m_ctrl[1]);
    pop[0] = cmd && wd[2] && !m_ctrl[2];
    pop[1] = cmd && wd[0] && !m_ctrl[0];
    clr[0] = cmd && !wd[2];
    clr[1] = cmd && !wd[0];
    ev[0] = rxe; ev[1] = txe;
    if (cmd) m_ctrl = wd[3:0];
    if (fl) begin
      for (int l = 0; l < 2; l++) begin
        mq[l].delete(); m_ovf[l] = 0; m_done[l] = 0;
      end
      return;
    end
    for (int l = 0; l < 2; l++) begin
      if (pop[l]) begin
        if (mq[l].size() > 0) m_data[l] = mq[l].pop_front();
        m_done[l] = 1;
      end else if (clr[l]) m_done[l] = 0;
      if (ev[l]) begin
        if (mq[l].size() < 16) mq[l].push_back(st);
        else m_ovf[l] = 1;
      end
    end
  endtask

  task automatic step(input bit wen, input logic [7:0] a, input logic [31:0] wd,
                      input bit rxe, input bit txe);
    reg_wen = wen; reg_addr = a; reg_wdata = wd;
    rx_evt = rxe; tx_evt = txe; tod_sec = tsec; tod_ns = tns;
    @(posedge clk);
    model_step(wen, a, wd, rxe, txe, {tsec, tns});
    @(negedge clk);
    reg_wen = 0; rx_evt = 0; tx_evt = 0;
    tsec = tsec + 32'd1;
    tns  = tns * 32'd5 + 32'd17;
    check(8'h50); check(8'h54); check(8'h58);
  endtask

  task automatic cmd(input logic [31:0] v);
    step(1, 8'h50, 32'd0, 0, 0);
    step(1, 8'h50, v, 0, 0);
  endtask

  task automatic check_data();
    check(8'h60); check(8'h64); check(8'h68); check(8'h6C);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_wen = 0; reg_addr = 0; reg_wdata = 0;
    rx_evt = 0; tx_evt = 0;
    tsec = 32'h0000_0100; tns = 32'h3B9A_C9F6;
    tod_sec = 0; tod_ns = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    cur_tag = "R10";
    check(8'h50); check(8'h54); check(8'h58); check_data();
    rst_n = 1;

    // R1 / R2: captures in both lanes, unmapped reads
    cur_tag = "R1";
    step(0, 8'h00, 0, 1, 0);
    step(0, 8'h00, 0, 0, 1);
    step(0, 8'h00, 0, 1, 1);
    step(0, 8'h00, 0, 1, 0);
    cur_tag = "R2";
    check(8'h5C); check(8'h00); check(8'h40);

    // R3 / R4: pops in order
    cur_tag = "R3";
    for (int k = 0; k < 2; k++) begin
      cmd(32'h4); check_data();
    end
    cmd(32'h1); check_data();
    cur_tag = "R4";
    step(1, 8'h50, 32'h0, 0, 0);

    // R5: command bit left high does not pop again
    cur_tag = "R5";
    step(1, 8'h50, 32'h4, 0, 0);
    step(1, 8'h50, 32'h4, 0, 0);
    step(1, 8'h50, 32'h5, 0, 0);
    step(1, 8'h50, 32'h5, 0, 0);
    check_data();

    // R6: overfill transmit lane
    cur_tag = "R6";
    for (int k = 0; k < 20; k++) step(0, 8'h00, 0, 0, 1);
    check(8'h58);

    // R7: pop from empty receive lane
    cur_tag = "R7";
    while (mq[0].size() > 0) cmd(32'h4);
    cmd(32'h4); check_data();

    // R8: capture and pop together on a full and a non-empty lane
    cur_tag = "R8";
    step(1, 8'h50, 32'h0, 0, 0);
    step(1, 8'h50, 32'h1, 1, 1);
    check_data();
    step(1, 8'h50, 32'h0, 1, 0);
    step(1, 8'h50, 32'h4, 1, 0);
    check_data();

    // R9: flush command
    cur_tag = "R9";
    step(1, 8'h50, 32'h0, 0, 0);
    step(1, 8'h50, 32'hF, 1, 1);
    check_data();
    step(1, 8'h50, 32'hA, 1, 0);

    // random mix
    cur_tag = "R8";
    for (int k = 0; k < 600; k++) begin
      int r;
      logic [31:0] v;
      r = int'($urandom_range(0, 99));
      case (r % 6)
        0: v = 32'h0;
        1: v = 32'h1;
        2: v = 32'h4;
        3: v = 32'h5;
        4: v = 32'h0;
        default: v = (r > 90) ? 32'hA : 32'h0;
      endcase
      step(r < 55, 8'h50, v, $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0);
      if (k % 37 == 0) check_data();
    end

    // R10: reset in mid-operation
    cur_tag = "R10";
    rst_n = 0;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    check(8'h50); check(8'h54); check(8'h58); check_data();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule